// File: doc/BRIEF.md
# Register-Bank Operand Fetch Sequencer

This block is the decode-and-fetch sequencer for one instruction family of an 8-bit microcontroller core: the family that copies a working register into the accumulator. A start strobe offers an opcode byte. When the upper five opcode bits match the family prefix, the sequencer waits a fixed number of cycles. It then reads the status word from internal RAM to learn which register bank is active. From the two bank-select bits and the three low opcode bits it builds the working-register address, reads that byte and latches it into an operand register. A one-cycle done pulse marks the result.

The RAM read port is synchronous. The block presents an address and a read strobe, and the RAM returns the byte in the next cycle. Address and strobe come straight from flip-flops, so the opcode-to-address path holds only a short mux level. The ALU, accumulator write-back and other opcodes sit outside this block.

Top module: `regbank_operand_fetch`

## Requirements
- R1: With start high in the idle state, an opcode whose bits [7:3] equal 11101 (0xE8 to 0xEF) is accepted. The low three bits are taken at that edge, so later opcode changes do not matter.
- R2: In the first three cycles after the accepting edge the read strobe stays low.
- R3: In cycles 4 and 5 after acceptance the read strobe is high and the address is 0xD0, the status word.
- R4: In cycles 6 and 7 the read strobe is high and the address is {3'b000, status[4:3], opcode[2:0]}, where status is the byte the RAM returned for 0xD0.
- R5: In cycle 8 the operand output holds the byte returned for the R4 address, and the read strobe is low.
- R6: Done is high for exactly cycle 8 after acceptance and low otherwise.
- R7: A start pulse while a sequence is in progress is ignored. The running sequence finishes unchanged and no second one follows.
- R8: An opcode outside the family leaves the block idle: no read strobe, no done pulse, the operand unchanged, and a new start is accepted in the next cycle.
- R9: While reset is low, the read strobe, done, address and operand are all zero, and a sequence in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer the opcode for decode |
| opcode | input | 8 | Instruction byte |
| ram_addr | output | 8 | Internal-RAM read address (registered) |
| ram_rd | output | 1 | Internal-RAM read strobe (registered) |
| ram_rdata | input | 8 | RAM read data, valid the cycle after the request |
| operand | output | 8 | Latched working-register value |
| done | output | 1 | One-cycle pulse when the operand is latched |

## Verification
The bench builds the block with its default parameters: three wait cycles, the status word at 0xD0, the bank field at status bits 4:3 and an 8-bit opcode with a 5-bit prefix. With these values one sequence lasts eight cycles, so each can be checked cycle by cycle. Randomised status bytes reach all four banks, and random opcodes reach all eight register indices as well as opcodes just outside the family (0xE7, 0xF0). The bench also covers a start pulse during a sequence and a reset in the middle of one.

// File: rtl/rbf_pkg.sv
`timescale 1ns/1ps
package rbf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT     = 3'd1,
    ST_STAT_RD  = 3'd2,
    ST_STAT_USE = 3'd3,
    ST_REG_RD   = 3'd4,
    ST_LATCH    = 3'd5
  } rbf_state_e;
endpackage

// File: rtl/rbf_group_decode.sv
`timescale 1ns/1ps
module rbf_group_decode #(
  parameter int OPC_W    = 8,
  parameter int PREFIX_W = 5,
  parameter int IDX_W    = 3,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b11101
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             hit,
  output logic [IDX_W-1:0] reg_idx
);
  // Prefix compare on the upper bits only: one narrow equality, no case list.
  assign hit     = (opcode[OPC_W-1 -: PREFIX_W] == PREFIX);
  assign reg_idx = opcode[IDX_W-1:0];
endmodule

// File: rtl/rbf_ctrl.sv
`timescale 1ns/1ps
module rbf_ctrl
  import rbf_pkg::*;
#(
  parameter int NUM_WAITS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       hit,
  output rbf_state_e state_q,
  output logic       accept,
  output logic       stat_issue
);
  localparam int CNT_W = (NUM_WAITS > 1) ? $clog2(NUM_WAITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_WAITS - 1);

  rbf_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             wait_last;

  assign accept     = (state_q == ST_IDLE) && start && hit;
  assign wait_last  = (state_q == ST_WAIT) && (cnt_q == CNT_LAST);
  assign stat_issue = wait_last;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (wait_last) begin
          state_d = ST_STAT_RD;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_STAT_RD:  state_d = ST_STAT_USE;
      ST_STAT_USE: state_d = ST_REG_RD;
      ST_REG_RD:   state_d = ST_LATCH;
      ST_LATCH:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rbf_port_regs.sv
`timescale 1ns/1ps
module rbf_port_regs
  import rbf_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 3,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rbf_state_e        state_q,
  input  logic              accept,
  input  logic              stat_issue,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd,
  output logic [DATA_W-1:0] operand,
  output logic              done
);
  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] bank_addr;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic              rd_d, rd_en;
  logic              opnd_en;
  logic              done_d;

  generate
    if (PAD_W > 0) begin : g_pad
      assign bank_addr = {{PAD_W{1'b0}}, rdata[BANK_LSB +: BANK_W], idx_q};
    end else begin : g_nopad
      assign bank_addr = {rdata[BANK_LSB +: BANK_W], idx_q};
    end
  endgenerate

  always_comb begin
    addr_en = stat_issue || (state_q == ST_STAT_USE);
    addr_d  = stat_issue ? STATUS_ADDR : bank_addr;
    rd_en   = stat_issue || (state_q == ST_LATCH);
    rd_d    = stat_issue;
    opnd_en = (state_q == ST_LATCH);
    done_d  = (state_q == ST_LATCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (accept) begin
      idx_q <= reg_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr <= '0;
    end else if (addr_en) begin
      ram_addr <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_rd <= 1'b0;
    end else if (rd_en) begin
      ram_rd <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand <= '0;
    end else if (opnd_en) begin
      operand <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end
endmodule

// File: rtl/regbank_operand_fetch.sv
`timescale 1ns/1ps
module regbank_operand_fetch
  import rbf_pkg::*;
#(
  parameter int OPC_W     = 8,
  parameter int PREFIX_W  = 5,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b11101,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 2,
  parameter int BANK_LSB  = 3,
  parameter int NUM_WAITS = 3,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] operand,
  output logic              done
);
  localparam int IDX_W = OPC_W - PREFIX_W;

  rbf_state_e       state_q;
  logic             hit;
  logic             accept;
  logic             stat_issue;
  logic [IDX_W-1:0] reg_idx;

  rbf_group_decode #(
    .OPC_W(OPC_W), .PREFIX_W(PREFIX_W), .IDX_W(IDX_W), .PREFIX(PREFIX)
  ) u_decode (
    .opcode (opcode),
    .hit    (hit),
    .reg_idx(reg_idx)
  );

  rbf_ctrl #(
    .NUM_WAITS(NUM_WAITS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hit       (hit),
    .state_q   (state_q),
    .accept    (accept),
    .stat_issue(stat_issue)
  );

  rbf_port_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .BANK_W(BANK_W), .BANK_LSB(BANK_LSB), .STATUS_ADDR(STATUS_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .accept    (accept),
    .stat_issue(stat_issue),
    .reg_idx   (reg_idx),
    .rdata     (ram_rdata),
    .ram_addr  (ram_addr),
    .ram_rd    (ram_rd),
    .operand   (operand),
    .done      (done)
  );
endmodule

// File: rtl/rbf_fetch_chk.sv
`timescale 1ns/1ps
module rbf_fetch_chk
  import rbf_pkg::*;
#(
  parameter int OPC_W    = 8,
  parameter int PREFIX_W = 5,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b11101,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_rd,
  input logic [DATA_W-1:0] ram_rdata,
  input logic [DATA_W-1:0] operand,
  input logic              done,
  input rbf_state_e        state_q
);
  localparam int IDX_W = OPC_W - PREFIX_W;
  localparam logic [ADDR_W:0] BANK_SPAN = (ADDR_W+1)'(1) << (BANK_W + IDX_W);

  logic in_group;
  assign in_group = (opcode[OPC_W-1 -: PREFIX_W] == PREFIX);

  // R1
  accept_enters_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && in_group) |=> (state_q == ST_WAIT));

  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !ram_rd);

  // R3
  first_read_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_rd) |-> (ram_addr == STATUS_ADDR));

  // R4
  bank_read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REG_RD) |-> (ram_rd && ({1'b0, ram_addr} < BANK_SPAN)));

  // R5
  operand_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (operand == $past(ram_rdata) && !ram_rd));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_WAIT && start) |=> (state_q != ST_WAIT));

  // R8
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && !in_group) |=> (state_q == ST_IDLE && !ram_rd && !done));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!ram_rd && !done && ram_addr == '0 && operand == '0));
endmodule

bind regbank_operand_fetch rbf_fetch_chk #(
  .OPC_W(OPC_W), .PREFIX_W(PREFIX_W), .PREFIX(PREFIX), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .BANK_W(BANK_W), .STATUS_ADDR(STATUS_ADDR)
) u_fetch_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .opcode   (opcode),
  .ram_addr (ram_addr),
  .ram_rd   (ram_rd),
  .ram_rdata(ram_rdata),
  .operand  (operand),
  .done     (done),
  .state_q  (state_q)
);

// File: tb/tb_regbank_operand_fetch.sv
`timescale 1ns/1ps
module tb_regbank_operand_fetch;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] opcode;
  logic [7:0] ram_addr;
  logic       ram_rd;
  logic [7:0] ram_rdata;
  logic [7:0] operand;
  logic       done;

  logic [7:0] mem [256];
  int n_tests;
  int n_fail;

  regbank_operand_fetch dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_rdata(ram_rdata),
    .operand(operand), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Synchronous RAM model: data for a request appears the next cycle.
  always @(posedge clk) begin
    if (ram_rd) ram_rdata <= mem[ram_addr];
  end

  function automatic bit is_group(input logic [7:0] op);
    return op[7:3] == 5'b11101;
  endfunction

  function automatic logic [7:0] bank_addr(input logic [7:0] st, input logic [7:0] op);
    return {3'b000, st[4:3], op[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_reset_outputs(input string tag);
    chk(ram_rd == 1'b0, tag, ram_rd, 0);
    chk(done == 1'b0, tag, done, 0);
    chk(ram_addr == 8'h00, tag, ram_addr, 0);
    chk(operand == 8'h00, tag, operand, 0);
  endtask

  task automatic run_group(input logic [7:0] opc, input bit poke_busy);
    logic [7:0] st, a, val;
    st = 8'($urandom);
    mem[8'hD0] = st;
    a = bank_addr(st, opc);
    val = 8'($urandom);
    mem[a] = val;
    @(negedge clk);
    opcode = opc; start = 1'b1;
    @(negedge clk);
    start = 1'b0; opcode = 8'($urandom);
    for (int k = 1; k <= 9; k++) begin
      if (poke_busy && k == 2) begin start = 1'b1; opcode = 8'hE8 | 8'($urandom % 8); end
      if (poke_busy && k == 3) start = 1'b0;
      if (k <= 3) chk(ram_rd == 1'b0, "R2 quiet wait", ram_rd, 0);
      if (k == 4 || k == 5) begin
        chk(ram_rd == 1'b1, "R3 status strobe", ram_rd, 1);
        chk(ram_addr == 8'hD0, "R3 status addr", ram_addr, 8'hD0);
      end
      if (k == 6 || k == 7) begin
        chk(ram_rd == 1'b1, "R4 register strobe", ram_rd, 1);
        chk(ram_addr == a, "R4 register addr (R1 index)", ram_addr, a);
      end
      if (k == 8) begin
        chk(done == 1'b1, "R6 done high", done, 1);
        chk(operand == val, "R5 operand value", operand, val);
        chk(ram_rd == 1'b0, "R5 strobe released", ram_rd, 0);
      end
      if (k < 8 || k == 9) chk(done == 1'b0, "R6 done low", done, 0);
      @(negedge clk);
    end
    if (poke_busy) begin
      for (int k = 0; k < 9; k++) begin
        chk(ram_rd == 1'b0, "R7 no restart strobe", ram_rd, 0);
        chk(done == 1'b0, "R7 no second done", done, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic run_reject(input logic [7:0] opc);
    logic [7:0] keep;
    keep = operand;
    @(negedge clk);
    opcode = opc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      chk(ram_rd == 1'b0, "R8 no access", ram_rd, 0);
      chk(done == 1'b0, "R8 no done", done, 0);
      @(negedge clk);
    end
    chk(operand == keep, "R8 operand kept", operand, keep);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    n_tests = 0;
    n_fail = 0;
    seed_v = $urandom(32'd51923);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    ram_rdata = 8'h00;
    start = 1'b0;
    opcode = 8'h00;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_reset_outputs("R9 reset state");
    rst_n = 1'b1;

    // Directed: family edges and neighbours
    run_group(8'hE8, 1'b0);
    run_group(8'hEF, 1'b0);
    run_reject(8'hE7);
    run_reject(8'hF0);
    // R8: accepted the cycle right after a reject
    @(negedge clk);
    opcode = 8'h12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_group(8'hEB, 1'b0);
    // R7: start while busy
    run_group(8'hED, 1'b1);

    // R9: reset in mid-sequence
    @(negedge clk);
    opcode = 8'hEA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset_outputs("R9 reset mid-sequence");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) begin
      chk(done == 1'b0, "R9 sequence abandoned", done, 0);
      @(negedge clk);
    end
    run_group(8'hEC, 1'b0);

    // Random mix (R1 recognition across opcodes)
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      op = (i % 2 == 0) ? (8'hE8 | 8'($urandom % 8)) : 8'($urandom);
      if (is_group(op)) run_group(op, (i % 7 == 3));
      else run_reject(op);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule